// File: doc/BRIEF.md
# Absolute Angle Serial Transmitter

This block is the sensor end of a clocked serial link that reports an absolute angle to a controller. The controller toggles a clock line. The block answers on a data line with one bit per rising edge of that clock. When a read begins, the block freezes the current angle and the error flag. It then sends a three-bit opening pattern, the angle word, two flag bits and an inverted six-bit checksum. A plainer 13-bit mode can be selected in place of this frame.

After the last bit of its own frame, the block forwards the data of the next sensor in a chain, which arrives on a separate input. The controller ends a read by stopping its clock. The block notices the silence after a set number of system clocks, returns its output to the idle high level and waits for the next read. The clock line is asynchronous to the system clock and passes through a synchronizer.

A resolution input reduces the number of meaningful angle bits. The kept bits are right-aligned in the 12-bit word, and the bits above them are sent as zeros.

Top module: `enc_pos_tx`

## Requirements
- R1: After reset, and while no read is in progress, `slo_o` is 1.
- R2: In the extended frame, the values presented after the first, second and third rising edges of `ma_i` in a read are 0, 1 and 0.
- R3: The next 12 edges present the angle word MSB first. The word is taken from `pos_i`, `res_i` and `err_i` at the first edge of the read. Changes to these inputs later in the read have no effect on that read.
- R4: When `res_i` is between 1 and 11, the word sent is `pos_i >> (12 - res_i)`, so its upper bits are zero. A value of 0, or of 12 or more, sends `pos_i` unchanged.
- R5: Edge 16 presents the inverse of `err_i`, so 0 means an error. Edge 17 always presents 1.
- R6: Edges 18 to 23 present the bitwise inverse of the remainder of (word, error bit, warning bit), 14 bits MSB first, multiplied by x^6 and divided by x^6 + x + 1. The remainder is sent highest bit first.
- R7: Each edge after the frame presents the value of `sli_i` sampled at that edge.
- R8: When no rising edge arrives for `TIMEOUT_CYC` system clocks, `slo_o` returns to 1. The next edge starts a new frame, and this holds even if the frame was cut short.
- R9: With `ssi_mode_i` at 1 on the first edge, the read sends 13 bits and then forwards the chain: a 0 followed by the padded word MSB first. The mode is sampled only on that first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ma_i | input | 1 | Clock line from the controller, idle high, asynchronous |
| sli_i | input | 1 | Data from the next sensor in the chain |
| pos_i | input | DATA_W | Absolute angle, full scale |
| res_i | input | RES_W | Number of meaningful angle bits (0 means full) |
| err_i | input | 1 | Active-high error condition |
| ssi_mode_i | input | 1 | 1 selects the 13-bit mode |
| slo_o | output | 1 | Serial data to the controller |

## Verification
The bench sweeps every `res_i` value from 0 to 15 with both error states and both modes. This covers the padding edges at 0, 11, 12 and 15. A shift that is off by one, or a clamp that is missing, would shift the whole word and corrupt the checksum. The checksum is checked against a reference computed by long division. A design that did not invert it, or that left the flag bits out of its coverage, fails on every frame. Further reads change every input after the first edge, including the mode, to catch a design that reads live inputs during a read. Another read is cut short after five bits, to catch a design that fails to rearm after a timeout in mid-frame.

// File: rtl/enc_tx_pkg.sv
package enc_tx_pkg;

    localparam int            HDR_W    = 3;
    localparam logic [2:0]    HDR_BITS = 3'b010;   // Ack, Start, control bit
    localparam int            FLAG_W   = 2;        // error, warning
    localparam int            CRC_W    = 6;
    localparam logic [5:0]    CRC_POLY = 6'b000011; // x^6 + x + 1 without the top term

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FRAME = 2'd1,
        PH_CHAIN = 2'd2
    } phase_e;

endpackage

// File: rtl/ma_edge_detect.sv
module ma_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ma_i,
    output logic rise_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    // the line idles high, so the chain is preset to ones
    always_comb begin
        sh_d = {sh_q[SH_W-2:0], ma_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= sh_d;
    end

    assign rise_o = sh_q[SH_W-2] & ~sh_q[SH_W-1];

endmodule

// File: rtl/crc_gen.sv
module crc_gen
    import enc_tx_pkg::*;
#(
    parameter int MSG_W = 14
) (
    input  logic [MSG_W-1:0] msg_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    // serial division unrolled, MSB first, register starting at zero
    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ msg_i[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc_o = acc;
    end

endmodule

// File: rtl/frame_builder.sv
module frame_builder
    import enc_tx_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int RES_W   = 4,
    parameter int FRAME_W = HDR_W + DATA_W + FLAG_W + CRC_W,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  pos_i,
    input  logic [RES_W-1:0]   res_i,
    input  logic               err_i,
    input  logic               ssi_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [LEN_W-1:0]   len_o
);
    localparam int MSG_W = DATA_W + FLAG_W;
    localparam int SSI_W = DATA_W + 1;

    logic [DATA_W-1:0] word;
    logic [MSG_W-1:0]  msg;
    logic [CRC_W-1:0]  crc;
    int                shift;

    // resolution padding: keep the top bits, right-aligned
    always_comb begin
        if (int'(res_i) == 0 || int'(res_i) >= DATA_W) shift = 0;
        else                                           shift = DATA_W - int'(res_i);
        word = pos_i >> shift;
        msg  = {word, ~err_i, 1'b1};
    end

    crc_gen #(.MSG_W(MSG_W)) u_crc (
        .msg_i (msg),
        .crc_o (crc)
    );

    always_comb begin
        if (ssi_i) begin
            frame_o = {1'b0, word, {(FRAME_W - SSI_W){1'b0}}};
            len_o   = LEN_W'(SSI_W);
        end else begin
            frame_o = {HDR_BITS, msg, ~crc};
            len_o   = LEN_W'(FRAME_W);
        end
    end

endmodule

// File: rtl/enc_pos_tx.sv
module enc_pos_tx
    import enc_tx_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int RES_W       = 4,
    parameter int TIMEOUT_CYC = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ma_i,
    input  logic              sli_i,
    input  logic [DATA_W-1:0] pos_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic              err_i,
    input  logic              ssi_mode_i,
    output logic              slo_o
);
    localparam int FRAME_W = HDR_W + DATA_W + FLAG_W + CRC_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int TMO_W   = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        phase_e             phase;
        logic [FRAME_W-1:0] shreg;
        logic [LEN_W-1:0]   left;
        logic [TMO_W-1:0]   tmo;
        logic               slo;
    } state_t;

    state_t             st_d, st_q;
    logic               ma_rise;
    logic               tmo_hit;
    logic               busy;
    logic               in_chain;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   flen;

    ma_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ma_i   (ma_i),
        .rise_o (ma_rise)
    );

    frame_builder #(
        .DATA_W  (DATA_W),
        .RES_W   (RES_W),
        .FRAME_W (FRAME_W),
        .LEN_W   (LEN_W)
    ) u_frame (
        .pos_i   (pos_i),
        .res_i   (res_i),
        .err_i   (err_i),
        .ssi_i   (ssi_mode_i),
        .frame_o (frame),
        .len_o   (flen)
    );

    always_comb begin
        st_d    = st_q;
        tmo_hit = 1'b0;
        if (ma_rise) begin
            st_d.tmo = '0;
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase = PH_FRAME;
                    st_d.slo   = frame[FRAME_W-1];
                    st_d.shreg = frame << 1;
                    st_d.left  = flen - 1'b1;
                end
                PH_FRAME: begin
                    if (st_q.left != '0) begin
                        st_d.slo   = st_q.shreg[FRAME_W-1];
                        st_d.shreg = st_q.shreg << 1;
                        st_d.left  = st_q.left - 1'b1;
                    end else begin
                        st_d.phase = PH_CHAIN;
                        st_d.slo   = sli_i;
                    end
                end
                default: begin
                    st_d.slo = sli_i;
                end
            endcase
        end else if (st_q.phase != PH_IDLE) begin
            if (st_q.tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
                tmo_hit    = 1'b1;
                st_d.phase = PH_IDLE;
                st_d.slo   = 1'b1;
                st_d.tmo   = '0;
                st_d.left  = '0;
            end else begin
                st_d.tmo = st_q.tmo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, shreg: '0, left: '0, tmo: '0, slo: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign in_chain = (st_q.phase == PH_CHAIN) ||
                      (st_q.phase == PH_FRAME && st_q.left == '0);
    assign slo_o    = st_q.slo;

endmodule

// File: rtl/enc_pos_tx_chk.sv
module enc_pos_tx_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic ma_rise,
    input logic tmo_hit,
    input logic busy,
    input logic in_chain,
    input logic sli_i,
    input logic slo_o
);
    p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |-> slo_o);

    p_first_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && ma_rise) |=> (busy && !slo_o));

    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ma_rise && !tmo_hit) |=> $stable(slo_o));

    p_forward_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_chain && ma_rise) |=> (slo_o == $past(sli_i)));

    p_timeout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_hit |=> (!busy && slo_o));

endmodule

bind enc_pos_tx enc_pos_tx_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ma_rise  (ma_rise),
    .tmo_hit  (tmo_hit),
    .busy     (busy),
    .in_chain (in_chain),
    .sli_i    (sli_i),
    .slo_o    (slo_o)
);

// File: tb/sim_enc_pos_tx.sv
module sim_enc_pos_tx;

    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ma;
    logic        sli;
    logic [11:0] pos;
    logic [3:0]  res;
    logic        err;
    logic        ssi;
    logic        slo;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    enc_pos_tx #(.DATA_W(12), .RES_W(4), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ma_i       (ma),
        .sli_i      (sli),
        .pos_i      (pos),
        .res_i      (res),
        .err_i      (err),
        .ssi_mode_i (ssi),
        .slo_o      (slo)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: slo=%0b expected %0b", tag, got, exp);
        end
    endtask

    // one controller clock period: low half then rising edge, sample late in the high half
    task automatic pulse();
        @(negedge clk) ma = 1'b0;
        repeat (7) @(negedge clk);
        ma = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // expected frame, MSB first, checksum by polynomial long division
    function automatic logic [22:0] exp_bits(input logic [11:0] p, input logic [3:0] r,
                                             input logic e, input logic s);
        int          rr  = (r == 0 || r >= 12) ? 12 : int'(r);
        logic [11:0] v   = p >> (12 - rr);
        logic [19:0] rem = {v, ~e, 1'b1, 6'b0};
        for (int i = 19; i >= 6; i--)
            if (rem[i]) rem = rem ^ (20'(7'b1000011) << (i - 6));
        if (s) return {1'b0, v, 10'b0};
        return {3'b010, v, ~e, 1'b1, ~rem[5:0]};
    endfunction

    task automatic run_frame(input logic [11:0] p, input logic [3:0] r, input logic e,
                             input logic s, input int nchain, input bit scramble);
        logic [22:0] ex;
        int          len;
        string       tag;
        pos = p; res = r; err = e; ssi = s;
        ex  = exp_bits(p, r, e, s);
        len = s ? 13 : 23;
        for (int k = 0; k < len; k++) begin
            sli = k[0];
            pulse();
            if (k == 0 && scramble) begin
                pos = ~p; res = ~r; err = ~e; ssi = ~s;
            end
            if (scramble)          tag = s ? "R9" : "R3";
            else if (s)            tag = "R9";
            else if (k < 3)        tag = "R2";
            else if (k < 15)       tag = (r >= 1 && r <= 11) ? "R4" : "R3";
            else if (k < 17)       tag = "R5";
            else                   tag = "R6";
            chk(slo, ex[22-k], tag);
        end
        for (int c = 0; c < nchain; c++) begin
            sli = ((c + int'(p)) % 3) == 1;
            pulse();
            chk(slo, sli, "R7");
        end
        repeat (TMO + 20) @(negedge clk);
        chk(slo, 1'b1, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ma = 1'b1; sli = 1'b0;
        pos = '0; res = '0; err = 1'b0; ssi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(slo, 1'b1, "R1");
        repeat (50) @(negedge clk);
        chk(slo, 1'b1, "R1");

        // sweep of resolution, error and mode
        for (int r = 0; r < 16; r++)
            for (int e = 0; e < 2; e++)
                for (int s = 0; s < 2; s++)
                    run_frame(12'((r * 397 + e * 1111 + s * 77 + 12'hA5C) & 12'hFFF),
                              4'(r), e[0], s[0], 3, 1'b0);

        // all-ones and all-zero words
        run_frame(12'hFFF, 4'd0, 1'b0, 1'b0, 2, 1'b0);
        run_frame(12'h000, 4'd12, 1'b1, 1'b0, 2, 1'b0);

        // inputs and mode change after the first edge
        run_frame(12'h3C5, 4'd12, 1'b0, 1'b0, 1, 1'b1);
        run_frame(12'h9A1, 4'd7, 1'b1, 1'b1, 1, 1'b1);

        // read cut short, then a full read
        pos = 12'h5A5; res = 4'd0; err = 1'b0; ssi = 1'b0;
        for (int k = 0; k < 5; k++) pulse();
        repeat (TMO + 20) @(negedge clk);
        chk(slo, 1'b1, "R8");
        run_frame(12'h777, 4'd10, 1'b0, 1'b0, 2, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule